// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with FIFO and Parity Modes

This block is the transmit half of a single asynchronous serial channel. Bytes written by the host land in a 16-entry first-in first-out store. A shift engine takes them out one at a time and puts each on the serial line as a framed character. A frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a high stop period. The line rests high between characters. Every bit lasts 16 pulses of a 16x baud enable, which is generated outside the block.

The character format comes from static inputs: word length, stop count, parity on/off and a two-bit parity mode. The block samples the format when a character starts, so a change only affects later characters. An active-low clear-to-send input gates the start of each character. Once a character has begun it always finishes. The block also gives a ready flag (the store has room), an empty flag (nothing stored and nothing on the wire) and an interrupt request that fires when the store drains.

The shift engine has five states. IDLE moves to START when the store holds data and clear-to-send is low (this is the "load" transition, which pops one byte). START moves to DATA after one bit time. DATA moves to PARITY after the last data bit when parity is on, and to STOP when it is off. PARITY moves to STOP after one bit time. STOP returns to IDLE when the stop period ends. After IDLE is re-entered, the next load takes one clock, so back-to-back characters are separated by one clock cycle.

Top module: `uart_tx`

## Requirements
- R1: With no character in progress the line is high. A character is sent as one low start bit, then `word_len`+5 data bits with the least significant bit first (`word_len` 0..3 gives 5..8 bits; higher data bits are not sent), then the stop period at high level.
- R2: Every start, data and parity bit lasts exactly 16 pulses of `tick16`. The engine advances only on clocks where `tick16` is high.
- R3: With `par_en`=0 no parity bit is sent. With `par_en`=1 one parity bit follows the data. `par_sel` 0 gives odd parity over the sent data bits, 1 gives even parity, 2 gives a constant 1 and 3 gives a constant 0.
- R4: The stop period lasts 16 ticks when `two_stop`=0 and 32 ticks when `two_stop`=1. The exception is a 5-bit word with `two_stop`=1, where it lasts 24 ticks.
- R5: Up to 16 bytes are stored and sent in the order written.
- R6: `tx_ready` is low exactly when 16 bytes are stored. A write while the store is full is discarded and leaves the stored bytes unchanged.
- R7: While `cts_n` is high no new character starts. A character already started is sent to its end.
- R8: An interrupt becomes pending when a transfer into the shift engine leaves the store empty. `irq` is the pending flag gated by `irq_en`.
- R9: The pending interrupt is cleared by a pulse on `irq_ack` or by an accepted write.
- R10: `tx_empty` is high only when the store is empty and no character is being sent.
- R11: After reset `txd`=1, `tx_ready`=1, `tx_empty`=1 and `irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | 16x baud enable pulse |
| wr_en | input | 1 | Write strobe for one byte |
| wr_data | input | 8 | Byte to transmit |
| word_len | input | 2 | Data bits minus 5 |
| two_stop | input | 1 | Long stop period select |
| par_en | input | 1 | Parity bit enable |
| par_sel | input | 2 | Parity mode: 0 odd, 1 even, 2 mark, 3 space |
| cts_n | input | 1 | Clear-to-send, active low |
| irq_en | input | 1 | Interrupt enable |
| irq_ack | input | 1 | Interrupt status read pulse, clears pending |
| txd | output | 1 | Serial output |
| irq | output | 1 | Transmit interrupt request |
| tx_ready | output | 1 | Store can accept a byte |
| tx_empty | output | 1 | Store and shift engine both empty |

## Verification
The hardest case to reach from the ports is flow control being withdrawn while a character is already on the wire and another byte is waiting. The stimulus writes one byte with `cts_n` low. It raises `cts_n` on the clock right after the load, then writes a second byte. This shows that the first frame finishes intact, that the line stays idle with `tx_empty` low, and that the second frame appears only after `cts_n` falls. The 1.5-stop case and the tick-spacing rule are checked by timing the distance between start edges of back-to-back characters. This distance is set by the bit count and stop period plus the single load clock.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_t;

    typedef enum logic [1:0] {
        PAR_ODD   = 2'd0,
        PAR_EVEN  = 2'd1,
        PAR_MARK  = 2'd2,
        PAR_SPACE = 2'd3
    } par_mode_t;

    typedef struct packed {
        logic [1:0] wlen;
        logic       two_stop;
        logic       par_en;
        par_mode_t  par_mode;
    } frame_cfg_t;

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full,
    output logic         last
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
    logic [CW-1:0] count;
    logic          push_ok, pop_ok;

    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;

    generate
        if ((1 << AW) == DEPTH) begin : g_pow2
            assign wr_nxt = wr_ptr + AW'(1);
            assign rd_nxt = rd_ptr + AW'(1);
        end else begin : g_wrap
            assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
            assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_nxt;
            if (pop_ok)  rd_ptr <= rd_nxt;
            if (push_ok && !pop_ok)      count <= count + CW'(1);
            else if (pop_ok && !push_ok) count <= count - CW'(1);
        end
    end

    assign dout  = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign last  = (count == CW'(1));

endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        wlen,
    input  par_mode_t         mode,
    output logic              pbit
);
    logic [DATA_W-1:0] masked;
    logic              ones_odd;

    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            masked[i] = data[i] && (i <= int'(wlen) + DATA_W - 4);
        end
        ones_odd = ^masked;
        unique case (mode)
            PAR_ODD:   pbit = ~ones_odd;
            PAR_EVEN:  pbit = ones_odd;
            PAR_MARK:  pbit = 1'b1;
            PAR_SPACE: pbit = 1'b0;
            default:   pbit = 1'b0;
        endcase
    end

endmodule

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int TPB    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cts_n,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    input  frame_cfg_t        cfg,
    input  logic              par_in,
    output logic              pop,
    output logic              txd,
    output logic              busy
);
    localparam int CNT_W = $clog2(2 * TPB);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(TPB - 1);
    localparam logic [CNT_W-1:0] LONG_LAST = CNT_W'(2 * TPB - 1);
    localparam logic [CNT_W-1:0] MID_LAST  = CNT_W'(TPB + TPB / 2 - 1);

    tx_state_t         state_q, state_d;
    frame_cfg_t        cfg_q;
    logic [DATA_W-1:0] shreg;
    logic [IDX_W-1:0]  bit_idx, last_idx;
    logic [CNT_W-1:0]  tick_cnt, cur_last, stop_last;
    logic              par_q, load, bit_end;

    assign load     = (state_q == ST_IDLE) && !fifo_empty && !cts_n;
    assign pop      = load;
    assign last_idx = IDX_W'(cfg_q.wlen) + IDX_W'(DATA_W - 4);

    always_comb begin
        if (!cfg_q.two_stop)        stop_last = BIT_LAST;
        else if (cfg_q.wlen == 2'd0) stop_last = MID_LAST;
        else                        stop_last = LONG_LAST;
        cur_last = (state_q == ST_STOP) ? stop_last : BIT_LAST;
        bit_end  = tick && (tick_cnt == cur_last);
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (load) state_d = ST_START;
            ST_START:  if (bit_end) state_d = ST_DATA;
            ST_DATA:   if (bit_end && bit_idx == last_idx)
                           state_d = cfg_q.par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_end) state_d = ST_STOP;
            ST_STOP:   if (bit_end) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // character datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            cfg_q    <= '0;
            par_q    <= 1'b0;
            bit_idx  <= '0;
            tick_cnt <= '0;
        end else if (load) begin
            shreg    <= fifo_data;
            cfg_q    <= cfg;
            par_q    <= par_in;
            bit_idx  <= '0;
            tick_cnt <= '0;
        end else if (state_q != ST_IDLE && tick) begin
            if (bit_end) begin
                tick_cnt <= '0;
                if (state_q == ST_DATA) begin
                    shreg   <= shreg >> 1;
                    bit_idx <= bit_idx + IDX_W'(1);
                end
            end else begin
                tick_cnt <= tick_cnt + CNT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        busy = (state_q != ST_IDLE);
        unique case (state_q)
            ST_IDLE:   txd = 1'b1;
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = shreg[0];
            ST_PARITY: txd = par_q;
            ST_STOP:   txd = 1'b1;
            default:   txd = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int TPB    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        word_len,
    input  logic              two_stop,
    input  logic              par_en,
    input  logic [1:0]        par_sel,
    input  logic              cts_n,
    input  logic              irq_en,
    input  logic              irq_ack,
    output logic              txd,
    output logic              irq,
    output logic              tx_ready,
    output logic              tx_empty
);
    frame_cfg_t        cfg;
    logic [DATA_W-1:0] head;
    logic              fifo_empty, fifo_full, fifo_last;
    logic              pop, push_ok, par_bit, tx_busy, irq_pend;

    assign cfg.wlen     = word_len;
    assign cfg.two_stop = two_stop;
    assign cfg.par_en   = par_en;
    assign cfg.par_mode = par_mode_t'(par_sel);
    assign push_ok      = wr_en && !fifo_full;

    uart_tx_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(wr_en), .din(wr_data),
        .pop(pop), .dout(head),
        .empty(fifo_empty), .full(fifo_full), .last(fifo_last)
    );

    uart_tx_parity #(.DATA_W(DATA_W)) u_par (
        .data(head), .wlen(word_len), .mode(cfg.par_mode), .pbit(par_bit)
    );

    uart_tx_fsm #(.DATA_W(DATA_W), .TPB(TPB)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .cts_n(cts_n),
        .fifo_empty(fifo_empty), .fifo_data(head), .cfg(cfg),
        .par_in(par_bit), .pop(pop), .txd(txd), .busy(tx_busy)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              irq_pend <= 1'b0;
        else if (pop && fifo_last && !push_ok)   irq_pend <= 1'b1;
        else if (push_ok || irq_ack)             irq_pend <= 1'b0;
    end

    assign irq      = irq_pend && irq_en;
    assign tx_ready = !fifo_full;
    assign tx_empty = fifo_empty && !tx_busy;

endmodule

// File: rtl/uart_tx_checker.sv
module uart_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic txd,
    input logic tx_empty,
    input logic tx_ready,
    input logic irq,
    input logic irq_en,
    input logic irq_ack,
    input logic wr_en,
    input logic cts_n,
    input logic busy
);
    p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);

    p_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_ready && cts_n && !busy) |=> !tx_ready);

    p_cts_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cts_n) |=> !busy);

    p_irq_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    p_write_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tx_ready) |=> !irq);

    p_ack_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !wr_en && tx_empty) |=> !irq);

    p_empty_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> txd);

endmodule

bind uart_tx uart_tx_checker u_chk (
    .clk(clk), .rst_n(rst_n), .txd(txd), .tx_empty(tx_empty),
    .tx_ready(tx_ready), .irq(irq), .irq_en(irq_en), .irq_ack(irq_ack),
    .wr_en(wr_en), .cts_n(cts_n), .busy(tx_busy)
);

// File: tb/uart_tx_test.sv
module uart_tx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] word_len = 2'd3;
    logic       two_stop = 1'b0;
    logic       par_en = 1'b0;
    logic [1:0] par_sel = 2'd0;
    logic       cts_n = 1'b0;
    logic       irq_en = 1'b0;
    logic       irq_ack = 1'b0;
    logic       txd, irq, tx_ready, tx_empty;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int div = 1;
    int tdc = 0;

    uart_tx uut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_en(wr_en),
        .wr_data(wr_data), .word_len(word_len), .two_stop(two_stop),
        .par_en(par_en), .par_sel(par_sel), .cts_n(cts_n),
        .irq_en(irq_en), .irq_ack(irq_ack), .txd(txd), .irq(irq),
        .tx_ready(tx_ready), .tx_empty(tx_empty)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) begin
        tick16 <= (tdc == 0);
        tdc    <= (tdc + 1 >= div) ? 0 : tdc + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_par(input logic [7:0] d, input int nb, input logic [1:0] m);
        logic x = 1'b0;
        for (int i = 0; i < nb; i++) x ^= d[i];
        case (m)
            2'd0: return ~x;
            2'd1: return x;
            2'd2: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic push(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // receive one frame in the current format; returns data, parity, start cycle
    task automatic grab(output logic [7:0] d, output logic p, output int t0);
        int w = 0;
        int nb = int'(word_len) + 5;
        d = '0; p = 1'b0; t0 = 0;
        while (txd !== 1'b0 && w < 6000) begin @(negedge clk); w++; end
        if (w >= 6000) begin chk("R1 start timeout", 0, 1); return; end
        t0 = cyc;
        repeat (8 * div) @(negedge clk);
        chk("R1 start bit", int'(txd), 0);
        for (int i = 0; i < nb; i++) begin
            repeat (16 * div) @(negedge clk);
            d[i] = txd;
        end
        if (par_en) begin
            repeat (16 * div) @(negedge clk);
            p = txd;
        end
        repeat (16 * div) @(negedge clk);
        chk("R1 stop level", int'(txd), 1);
    endtask

    task automatic t_reset();
        chk("R11 txd", int'(txd), 1);
        chk("R11 tx_ready", int'(tx_ready), 1);
        chk("R11 tx_empty", int'(tx_empty), 1);
        chk("R11 irq", int'(irq), 0);
    endtask

    task automatic t_frame(input logic [1:0] wl, input logic pe, input logic [1:0] ps,
                           input logic ts, input logic [7:0] d);
        logic [7:0] got, mask;
        logic p;
        int t0;
        word_len = wl; par_en = pe; par_sel = ps; two_stop = ts;
        mask = 8'hFF >> (3 - int'(wl));
        push(d);
        grab(got, p, t0);
        chk("R1 data bits", int'(got), int'(d & mask));
        if (pe) chk("R3 parity bit", int'(p), int'(exp_par(d, int'(wl) + 5, ps)));
        repeat (40 * div) @(negedge clk);
    endtask

    // distance between start edges of back-to-back characters
    task automatic t_spacing(input logic [1:0] wl, input logic pe, input logic ts,
                             input int n, input int exp_gap, input string tag);
        logic [7:0] g; logic p; int ta, tb;
        word_len = wl; par_en = pe; two_stop = ts;
        cts_n = 1'b1;
        for (int i = 0; i < n; i++) push(8'h5A + 8'(i));
        @(negedge clk); cts_n = 1'b0;
        grab(g, p, ta);
        for (int i = 1; i < n; i++) begin
            grab(g, p, tb);
            if (i == n - 1) chk(tag, tb - ta, exp_gap);
            ta = tb;
        end
        repeat (60 * div) @(negedge clk);
    endtask

    task automatic t_fifo_full();
        logic [7:0] g; logic p; int t0; int idle_bad = 0;
        word_len = 2'd3; par_en = 1'b0; two_stop = 1'b0;
        cts_n = 1'b1;
        for (int i = 0; i < 16; i++) push(8'(i * 7 + 1));
        chk("R6 ready low when full", int'(tx_ready), 0);
        push(8'hEE);
        chk("R6 ready still low", int'(tx_ready), 0);
        @(negedge clk); cts_n = 1'b0;
        for (int i = 0; i < 16; i++) begin
            grab(g, p, t0);
            chk("R5 fifo order", int'(g), i * 7 + 1);
        end
        repeat (20) @(negedge clk);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) idle_bad++;
        end
        chk("R6 dropped write not sent", idle_bad, 0);
        chk("R10 empty after drain", int'(tx_empty), 1);
    endtask

    task automatic t_cts_mid();
        logic [7:0] g; logic p; int t0; int moved = 0;
        word_len = 2'd3; par_en = 1'b1; par_sel = 2'd1; two_stop = 1'b0;
        cts_n = 1'b0;
        @(negedge clk); wr_en = 1'b1; wr_data = 8'hC3;
        @(negedge clk); wr_en = 1'b0;
        @(negedge clk); cts_n = 1'b1;
        push(8'h17);
        grab(g, p, t0);
        chk("R7 char in progress completes", int'(g), 8'hC3);
        chk("R7 parity of held char", int'(p), int'(exp_par(8'hC3, 8, 2'd1)));
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) moved++;
        end
        chk("R7 no start while cts high", moved, 0);
        chk("R10 not empty with byte held", int'(tx_empty), 0);
        cts_n = 1'b0;
        grab(g, p, t0);
        chk("R7 resumes after cts low", int'(g), 8'h17);
        repeat (40) @(negedge clk);
    endtask

    task automatic t_irq();
        logic [7:0] g; logic p; int t0;
        word_len = 2'd3; par_en = 1'b0; two_stop = 1'b0;
        irq_en = 1'b1; cts_n = 1'b0;
        push(8'h81);
        @(negedge clk);
        chk("R8 irq on store drain", int'(irq), 1);
        chk("R10 not empty while sending", int'(tx_empty), 0);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        chk("R9 ack clears irq", int'(irq), 0);
        grab(g, p, t0);
        chk("R1 irq test data", int'(g), 8'h81);
        repeat (20) @(negedge clk);
        push(8'h42);
        @(negedge clk);
        chk("R8 irq set again", int'(irq), 1);
        cts_n = 1'b1;
        grab(g, p, t0);
        repeat (20) @(negedge clk);
        push(8'h24);
        chk("R9 write clears irq", int'(irq), 0);
        irq_en = 1'b0;
        cts_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 irq masked by enable", int'(irq), 0);
        irq_en = 1'b1;
        @(negedge clk);
        chk("R8 pending shows when enabled", int'(irq), 1);
        grab(g, p, t0);
        chk("R5 held byte sent", int'(g), 8'h24);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        irq_en = 1'b0;
        repeat (40) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_frame(2'd3, 1'b0, 2'd0, 1'b0, 8'hA5);
        t_frame(2'd3, 1'b1, 2'd0, 1'b0, 8'h6B);
        t_frame(2'd2, 1'b1, 2'd1, 1'b0, 8'hBC);
        t_frame(2'd0, 1'b1, 2'd0, 1'b1, 8'hF3);
        t_frame(2'd1, 1'b1, 2'd2, 1'b0, 8'h00);
        t_frame(2'd3, 1'b1, 2'd3, 1'b0, 8'hFF);
        t_spacing(2'd3, 1'b0, 1'b0, 2, 161, "R4 one stop gap");
        t_spacing(2'd3, 1'b0, 1'b1, 2, 177, "R4 two stop gap");
        t_spacing(2'd0, 1'b0, 1'b1, 2, 121, "R4 one-and-half stop gap");
        t_spacing(2'd1, 1'b1, 1'b0, 2, 145, "R3 parity adds one bit");
        div = 3;
        repeat (6) @(negedge clk);
        t_frame(2'd3, 1'b1, 2'd1, 1'b0, 8'h9E);
        t_spacing(2'd3, 1'b0, 1'b0, 3, 480, "R2 bit time in ticks");
        div = 1;
        repeat (6) @(negedge clk);
        t_fifo_full();
        t_cts_mid();
        t_irq();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule